// File: doc/BRIEF.md
# Serial Port Transmit/Receive FIFO Pair with Trigger Flags

This block holds the byte buffering for one serial port. It has two 16-entry, 8-bit FIFOs. The transmit FIFO is filled by the CPU and drained by a transmit shifter. The receive FIFO is filled by a receive shifter and drained by the CPU. A single 8-bit control word sets up both FIFOs.

The control word picks a fill threshold for each FIFO from a small fixed table. From these thresholds the block derives two level flags:

- **Receive-ready flag:** set once enough bytes have arrived.
- **Transmit-low flag:** set once few enough bytes remain to be sent.

The same control word also has:

- a self-held clear bit for each FIFO;
- a loopback enable bit and a modem-handshake enable bit, which are passed out to the surrounding serial logic.

Shifters, baud timing and interrupt routing sit outside the block. They connect only through the push and pop strobes, the count outputs and the flags.

Top module: `uart_fifo_pair`

## Requirements
- R1: After reset the control word reads 0x00, both counts are 0 and both overflow indications are 0. A control write is read back unchanged on the next cycle. Bit layout, most significant first: bits 7:6 receive threshold code, bits 5:4 transmit threshold code, bit 3 modem enable, bit 2 transmit clear, bit 1 receive clear, bit 0 loopback enable.
- R2: A cycle with the standby input high returns the control word to 0x00. Standby takes priority over a control write in the same cycle.
- R3: The receive-ready flag is 1 exactly when the receive count is at or above the selected level. Codes 00, 01, 10 and 11 select levels 1, 4, 8 and 14.
- R4: The transmit-low flag is 1 exactly when the transmit count is at or below the selected level. Codes 00, 01, 10 and 11 select levels 8, 4, 2 and 1. A transmit count of 0 always gives 1.
- R5: Each FIFO returns bytes in the order they were pushed. It holds up to 16 bytes. A popped byte appears on the read-data output one cycle after the pop strobe. The count output gives the number of bytes stored.
- R6: A push to a full FIFO with no pop in the same cycle is dropped. The count stays at 16, and that FIFO's overflow indication becomes 1 and stays 1 until its clear bit is set.
- R7: A pop from an empty FIFO leaves the read-data output at its previous value and the count at 0.
- R8: Setting the transmit clear bit empties only the transmit FIFO and clears its overflow indication. Setting the receive clear bit does the same for the receive FIFO only. The effect is visible two cycles after the write strobe.
- R9: While a FIFO's clear bit stays at 1, pushes to that FIFO are ignored and its count stays 0. After software writes the bit back to 0, pushes are accepted again.
- R10: The loopback output follows control bit 0 and the modem enable output follows control bit 3.
- R11: A push and a pop to a non-empty FIFO in the same cycle are both carried out and leave the count unchanged, including when the FIFO is full. A push together with a pop to an empty FIFO stores the byte and leaves the count at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| standby | input | 1 | Standby / module stop, clears the control word |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 8 | Control word write data |
| cfg_rdata | output | 8 | Control word read data |
| tx_push | input | 1 | Push strobe into the transmit FIFO (CPU side) |
| tx_wdata | input | 8 | Byte to push into the transmit FIFO |
| tx_pop | input | 1 | Pop strobe from the transmit FIFO (shifter side) |
| tx_rdata | output | 8 | Last byte popped from the transmit FIFO |
| tx_count | output | 5 | Bytes stored in the transmit FIFO |
| tx_ovf | output | 1 | Sticky transmit overflow indication |
| tx_low | output | 1 | Transmit-low flag |
| rx_push | input | 1 | Push strobe into the receive FIFO (shifter side) |
| rx_wdata | input | 8 | Byte to push into the receive FIFO |
| rx_pop | input | 1 | Pop strobe from the receive FIFO (CPU side) |
| rx_rdata | output | 8 | Last byte popped from the receive FIFO |
| rx_count | output | 5 | Bytes stored in the receive FIFO |
| rx_ovf | output | 1 | Sticky receive overflow indication |
| rx_ready | output | 1 | Receive-ready flag |
| loop_en | output | 1 | Loopback enable to the serial shifters |
| modem_en | output | 1 | Modem handshake enable |

## Verification
The two functions that can fall in the same cycle are a push and a pop on one FIFO. The bench provokes this on a full transmit FIFO, on a partly filled receive FIFO and on an empty receive FIFO.

The driver adds each accepted byte to a queue before the clock edge. It also notes whether the pop will be honoured, judged from the queue depth before that push. The monitor then compares every honoured pop against the head of the queue one cycle later. The count is checked directly: it must stay unchanged when the FIFO was non-empty, and must become 1 when the FIFO was empty.

// File: rtl/uart_fifo_pkg.sv
// Shared types and threshold tables for the serial FIFO pair.
// Assumes a 16-entry FIFO; the threshold tables are fixed by the encoding.
package uart_fifo_pkg;

    localparam int LVL_W = 5;

    // Control word; field order sets the bit positions seen by software.
    typedef struct packed {
        logic [1:0] rx_code;
        logic [1:0] tx_code;
        logic       modem_en;
        logic       tx_clr;
        logic       rx_clr;
        logic       loop_en;
    } fifo_ctrl_t;

    // Receive threshold: how many stored bytes raise the ready flag.
    function automatic logic [LVL_W-1:0] rx_level(input logic [1:0] code);
        case (code)
            2'b00:   return LVL_W'(1);
            2'b01:   return LVL_W'(4);
            2'b10:   return LVL_W'(8);
            default: return LVL_W'(14);
        endcase
    endfunction

    // Transmit threshold: at or below this many bytes the low flag rises.
    function automatic logic [LVL_W-1:0] tx_level(input logic [1:0] code);
        case (code)
            2'b00:   return LVL_W'(8);
            2'b01:   return LVL_W'(4);
            2'b10:   return LVL_W'(2);
            default: return LVL_W'(1);
        endcase
    endfunction

endpackage

// File: rtl/fifo_ctrl_reg.sv
// Control word register for the FIFO pair.
// Assumes standby is synchronous and outranks a write in the same cycle.
module fifo_ctrl_reg
    import uart_fifo_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       standby,
    input  logic       we,
    input  logic [7:0] wdata,
    output fifo_ctrl_t ctrl
);

    // Hold the control word; reset and standby both return it to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || standby) begin
            ctrl <= '0;
        end else if (we) begin
            ctrl <= fifo_ctrl_t'(wdata);
        end
    end

    p_standby_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> (ctrl == '0));

    p_write_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !standby) |=> (ctrl == fifo_ctrl_t'($past(wdata))));

endmodule

// File: rtl/fifo_buf.sv
// Synchronous FIFO with sticky overflow and a level-held clear.
// Assumes DEPTH is a power of two. Read data is registered and holds its
// value when no pop is honoured. While clr is high the FIFO is held empty.
module fifo_buf #(
    parameter int DW    = 8,
    parameter int DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] rdata,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic          ovf
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          pop_ok;
    logic          push_ok;
    logic          push_drop;

    // Decide which strobes take effect this cycle.
    always_comb begin
        pop_ok    = pop && !clr && (count != '0);
        push_ok   = push && !clr && ((count < CW'(DEPTH)) || pop_ok);
        push_drop = push && !clr && !push_ok;
    end

    // Store accepted bytes.
    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= wdata;
        end
    end

    // Pointers, count, read data and overflow state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            rdata  <= '0;
            ovf    <= 1'b0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            ovf    <= 1'b0;
        end else begin
            if (push_ok) begin
                wr_ptr <= wr_ptr + AW'(1);
            end
            if (pop_ok) begin
                rdata  <= mem[rd_ptr];
                rd_ptr <= rd_ptr + AW'(1);
            end
            count <= count + CW'(push_ok) - CW'(pop_ok);
            if (push_drop) begin
                ovf <= 1'b1;
            end
        end
    end

    p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    p_full_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CW'(DEPTH) && push && !pop && !clr)
            |=> (count == CW'(DEPTH) && ovf));

    p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !clr) |=> ovf);

    p_empty_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && pop && !push && !clr) |=> ($stable(rdata) && count == '0));

    p_clear_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0 && !ovf));

    p_pushpop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !clr && count != '0) |=> $stable(count));

endmodule

// File: rtl/fifo_trig_flags.sv
// Level flags from FIFO counts and the threshold codes.
// Assumes counts no wider than needed for a 16-entry FIFO.
module fifo_trig_flags
    import uart_fifo_pkg::*;
#(
    parameter int CW = 5
) (
    input  logic [1:0]    rx_code,
    input  logic [1:0]    tx_code,
    input  logic [CW-1:0] rx_count,
    input  logic [CW-1:0] tx_count,
    output logic          rx_ready,
    output logic          tx_low
);

    // Compare each count against its table level every cycle.
    always_comb begin
        rx_ready = (rx_count >= CW'(rx_level(rx_code)));
        tx_low   = (tx_count <= CW'(tx_level(tx_code)));
    end

endmodule

// File: rtl/uart_fifo_pair.sv
// Transmit and receive byte FIFOs with threshold flags and a control word.
// Assumes the shifters honour the push/pop strobes one per cycle. The clear
// bits act from the cycle after the control write and hold while set.
module uart_fifo_pair
    import uart_fifo_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          standby,
    input  logic          cfg_we,
    input  logic [7:0]    cfg_wdata,
    output logic [7:0]    cfg_rdata,
    input  logic          tx_push,
    input  logic [DW-1:0] tx_wdata,
    input  logic          tx_pop,
    output logic [DW-1:0] tx_rdata,
    output logic [CW-1:0] tx_count,
    output logic          tx_ovf,
    output logic          tx_low,
    input  logic          rx_push,
    input  logic [DW-1:0] rx_wdata,
    input  logic          rx_pop,
    output logic [DW-1:0] rx_rdata,
    output logic [CW-1:0] rx_count,
    output logic          rx_ovf,
    output logic          rx_ready,
    output logic          loop_en,
    output logic          modem_en
);

    fifo_ctrl_t ctrl;

    fifo_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .standby (standby),
        .we      (cfg_we),
        .wdata   (cfg_wdata),
        .ctrl    (ctrl)
    );

    fifo_buf #(.DW(DW), .DEPTH(DEPTH)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ctrl.tx_clr),
        .push  (tx_push),
        .wdata (tx_wdata),
        .pop   (tx_pop),
        .rdata (tx_rdata),
        .count (tx_count),
        .ovf   (tx_ovf)
    );

    fifo_buf #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ctrl.rx_clr),
        .push  (rx_push),
        .wdata (rx_wdata),
        .pop   (rx_pop),
        .rdata (rx_rdata),
        .count (rx_count),
        .ovf   (rx_ovf)
    );

    fifo_trig_flags #(.CW(CW)) u_flags (
        .rx_code  (ctrl.rx_code),
        .tx_code  (ctrl.tx_code),
        .rx_count (rx_count),
        .tx_count (tx_count),
        .rx_ready (rx_ready),
        .tx_low   (tx_low)
    );

    // Expose the control word and its pass-through enables.
    always_comb begin
        cfg_rdata = ctrl;
        loop_en   = ctrl.loop_en;
        modem_en  = ctrl.modem_en;
    end

    p_tx_zero_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count == '0) |-> tx_low);

    p_rx_zero_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count == '0) |-> !rx_ready);

    p_clear_isolated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.tx_clr && !ctrl.rx_clr && !rx_push && !rx_pop) |=> $stable(rx_count));

endmodule

// File: tb/sim_uart_fifo_pair.sv
// Scoreboard bench: driver tasks queue expected bytes, monitors compare pops.
module sim_uart_fifo_pair;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       standby = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
    logic [7:0] tx_wdata = '0, rx_wdata = '0, tx_rdata, rx_rdata;
    logic [4:0] tx_count, rx_count;
    logic       tx_ovf, rx_ovf, tx_low, rx_ready, loop_en, modem_en;

    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    bit   tx_pe = 1'b0, rx_pe = 1'b0;
    bit   tx_held = 1'b0, rx_held = 1'b0;
    logic [7:0] tx_q[$];
    logic [7:0] rx_q[$];

    always #5 clk = ~clk;

    uart_fifo_pair u0 (
        .clk(clk), .rst_n(rst_n), .standby(standby),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop),
        .tx_rdata(tx_rdata), .tx_count(tx_count), .tx_ovf(tx_ovf), .tx_low(tx_low),
        .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop),
        .rx_rdata(rx_rdata), .rx_count(rx_count), .rx_ovf(rx_ovf), .rx_ready(rx_ready),
        .loop_en(loop_en), .modem_en(modem_en)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Control write plus one idle cycle so a clear bit has taken effect.
    task automatic wr(input logic [7:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        @(posedge clk);
        if (v[2]) tx_q.delete();
        if (v[1]) rx_q.delete();
        tx_held = v[2]; rx_held = v[1];
        @(negedge clk);
        cfg_we = 1'b0;
        @(posedge clk); @(negedge clk);
    endtask

    task automatic tx_op(input bit do_push, input bit do_pop, input logic [7:0] b);
        tx_pe = do_pop && !tx_held && (tx_q.size() > 0);
        if (do_push && !tx_held && (tx_q.size() < 16 || tx_pe)) tx_q.push_back(b);
        tx_push = do_push; tx_pop = do_pop; tx_wdata = b;
        @(posedge clk); @(negedge clk);
        tx_push = 1'b0; tx_pop = 1'b0; tx_pe = 1'b0;
    endtask

    task automatic rx_op(input bit do_push, input bit do_pop, input logic [7:0] b);
        rx_pe = do_pop && !rx_held && (rx_q.size() > 0);
        if (do_push && !rx_held && (rx_q.size() < 16 || rx_pe)) rx_q.push_back(b);
        rx_push = do_push; rx_pop = do_pop; rx_wdata = b;
        @(posedge clk); @(negedge clk);
        rx_push = 1'b0; rx_pop = 1'b0; rx_pe = 1'b0;
    endtask

    // Monitors: each honoured pop must yield the queue head (R5).
    initial forever begin
        @(posedge clk);
        if (tx_pe) begin
            automatic logic [7:0] e = tx_q.pop_front();
            @(negedge clk);
            chk("R5 tx order", tx_rdata, e);
        end
    end

    initial forever begin
        @(posedge clk);
        if (rx_pe) begin
            automatic logic [7:0] e = rx_q.pop_front();
            @(negedge clk);
            chk("R5 rx order", rx_rdata, e);
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ctrl reset", cfg_rdata, 0);
        chk("R1 tx count reset", tx_count, 0);
        chk("R1 rx count reset", rx_count, 0);
        chk("R1 ovf reset", {tx_ovf, rx_ovf}, 0);
        chk("R4 empty tx low", tx_low, 1);
        chk("R3 empty rx not ready", rx_ready, 0);

        // R1 readback, R10 pass-through enables
        wr(8'h89);
        chk("R1 readback", cfg_rdata, 8'h89);
        chk("R10 loop on", loop_en, 1);
        chk("R10 modem on", modem_en, 1);
        wr(8'h30);
        chk("R10 loop off", loop_en, 0);
        chk("R10 modem off", modem_en, 0);

        // R3 receive threshold per code
        for (int c = 0; c < 4; c++) begin
            automatic int lvl = (c == 0) ? 1 : (c == 1) ? 4 : (c == 2) ? 8 : 14;
            wr(8'((c << 6) | 2));
            wr(8'(c << 6));
            for (int i = 0; i < lvl - 1; i++) rx_op(1, 0, 8'(i));
            chk("R3 below level", rx_ready, 0);
            rx_op(1, 0, 8'hA0);
            chk("R3 at level", rx_ready, 1);
        end

        // R4 transmit threshold per code
        for (int c = 0; c < 4; c++) begin
            automatic int lvl = (c == 0) ? 8 : (c == 1) ? 4 : (c == 2) ? 2 : 1;
            wr(8'((c << 4) | 4));
            wr(8'(c << 4));
            chk("R4 zero count low", tx_low, 1);
            for (int i = 0; i < lvl; i++) tx_op(1, 0, 8'(i));
            chk("R4 at level", tx_low, 1);
            tx_op(1, 0, 8'hB0);
            chk("R4 above level", tx_low, 0);
        end

        // R5/R6/R11/R7 on the transmit FIFO
        wr(8'h06);
        wr(8'h00);
        for (int i = 0; i < 16; i++) tx_op(1, 0, 8'(i * 7 + 3));
        chk("R5 full count", tx_count, 16);
        chk("R6 no ovf yet", tx_ovf, 0);
        tx_op(1, 0, 8'hEE);
        chk("R6 drop count", tx_count, 16);
        chk("R6 ovf set", tx_ovf, 1);
        tx_op(1, 1, 8'h55);
        chk("R11 full push+pop count", tx_count, 16);
        for (int i = 0; i < 16; i++) tx_op(0, 1, 8'h00);
        chk("R5 drained", tx_count, 0);
        chk("R6 ovf sticky", tx_ovf, 1);
        tx_op(0, 1, 8'h00);
        chk("R7 empty pop holds data", tx_rdata, 8'h55);
        chk("R7 empty pop count", tx_count, 0);

        // R11 on the receive FIFO
        for (int i = 0; i < 5; i++) rx_op(1, 0, 8'(8'h40 + i));
        rx_op(1, 1, 8'h60);
        rx_op(1, 1, 8'h61);
        chk("R11 partial push+pop count", rx_count, 5);
        for (int i = 0; i < 5; i++) rx_op(0, 1, 8'h00);
        rx_op(1, 1, 8'h77);
        chk("R11 empty push+pop count", rx_count, 1);
        rx_op(0, 1, 8'h00);

        // R8 transmit clear isolated from receive, R9 held clear
        for (int i = 0; i < 3; i++) tx_op(1, 0, 8'(8'h90 + i));
        for (int i = 0; i < 2; i++) rx_op(1, 0, 8'(8'hC0 + i));
        wr(8'h04);
        chk("R8 tx cleared", tx_count, 0);
        chk("R8 tx ovf cleared", tx_ovf, 0);
        chk("R8 rx untouched", rx_count, 2);
        tx_op(1, 0, 8'h11);
        chk("R9 push ignored while held", tx_count, 0);
        wr(8'h00);
        tx_op(1, 0, 8'h12);
        chk("R9 push after release", tx_count, 1);
        wr(8'h02);
        chk("R8 rx cleared", rx_count, 0);
        chk("R8 tx untouched", tx_count, 1);
        wr(8'h00);
        tx_op(0, 1, 8'h00);

        // R2 standby clears control
        wr(8'hF1);
        standby = 1'b1; cfg_we = 1'b1; cfg_wdata = 8'h3C;
        @(posedge clk); @(negedge clk);
        standby = 1'b0; cfg_we = 1'b0;
        chk("R2 standby clear", cfg_rdata, 0);
        chk("R2 loop dropped", loop_en, 0);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule